// File: doc/BRIEF.md
# Microprogrammed Sequencer for a Shift-Add Multiplier

This block sequences an unsigned shift-add multiplier. It has no state machine in gates. A small constant control store holds one 12-bit microword per step. A 3-bit control address register selects the current microword. That word drives four datapath strobes: clear the accumulator and load the bit counter, add the multiplicand, clear the carry, and shift right while decrementing the counter. The same word also carries two candidate successor addresses.

A 2-bit selector field in the word chooses which status line, if any, decides between the two successors. The status lines are go, the low bit of the multiplier, and counter-is-zero. A 4-to-1 condition multiplexer feeds a 2-to-1 address multiplexer, and the result is loaded into the address register on each clock. The strobes are combinational from the current word and act on the datapath at the next edge. The datapath itself lives outside the block.

Top module: `mul_seq_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) loads the control address with 000. Out of reset all four strobes are low.
- R2: At address 000 (idle) no strobe is asserted. The next address is 001 when `go_i` is 1 and stays 000 when `go_i` is 0.
- R3: At address 001 (init) `init_o` and `clr_carry_o` are 1 and the other strobes are 0. The next address is always 010.
- R4: At address 010 (test) no strobe is asserted. The next address is 011 when `mplr_lsb_i` is 1 and 100 when it is 0.
- R5: At address 011 (add) only `load_o` is 1. The next address is always 100.
- R6: At address 100 (shift) `clr_carry_o` and `shift_dec_o` are 1 and the others are 0. The next address is 000 when `cnt_zero_i` is 1 and 010 when it is 0.
- R7: Status lines not chosen by the current word's selector have no effect on the next address. The selector codes are 00 = take the first-successor field unconditionally, 01 = go, 10 = multiplier low bit, 11 = counter zero. The microword layout is: alternate successor in bits 11:9, default successor in 8:6, selector in 5:4, and strobes in 3:0 (bit 0 init, 1 load, 2 clear carry, 3 shift/decrement).
- R8: The control address never leaves the five used codes 000 to 100.
- R9: Driving an N-bit shift-add datapath whose counter starts at N-1 returns to 000 exactly 1 + 2N + (number of ones in the multiplier) clock edges after the edge that leaves idle. At that point {A,Q} holds the full 2N-bit product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go_i | input | 1 | Start request |
| mplr_lsb_i | input | 1 | Low bit of the multiplier shift register |
| cnt_zero_i | input | 1 | Bit counter equals zero |
| ctl_addr_o | output | 3 | Current control address |
| init_o | output | 1 | Clear accumulator, load counter with N-1 |
| load_o | output | 1 | Add multiplicand into accumulator, capture carry |
| clr_carry_o | output | 1 | Clear carry flip-flop |
| shift_dec_o | output | 1 | Shift carry/accumulator/multiplier right, decrement counter |

## Verification
In the shift step, the carry clear and the right shift are issued in the same cycle. The datapath must move the old carry into the accumulator's top bit while it zeroes the flag, and a wrong ordering only shows when an add has just overflowed. The bench provokes this by sweeping every pair of 4-bit operands, including all-ones multiplicands that carry on nearly every add. It judges the result by the product that the modelled datapath holds on return to idle. Separately, each step is reached under forced status lines, and all eight status combinations are applied there to confirm that only the selected line steers.

// File: rtl/mulseq_pkg.sv
`timescale 1ns/1ps
package mulseq_pkg;
  localparam int ADDR_W = 3;
  localparam int SEL_W  = 2;
  localparam int DP_W   = 4;
  localparam int UW_W   = 2*ADDR_W + SEL_W + DP_W;
  localparam int DEPTH  = 1 << ADDR_W;

  // strobe bit positions inside the datapath field
  localparam int DP_INIT  = 0;
  localparam int DP_LOAD  = 1;
  localparam int DP_CLRC  = 2;
  localparam int DP_SHDEC = 3;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DP_W-1:0]   dp_t;

  typedef enum logic [SEL_W-1:0] {
    SQ_NEXT = 2'b00,
    SQ_GO   = 2'b01,
    SQ_LSB  = 2'b10,
    SQ_ZERO = 2'b11
  } seq_e;

  // msb first: alternate successor, default successor, selector, strobes
  typedef struct packed {
    addr_t nxt_alt;
    addr_t nxt_dflt;
    seq_e  sel;
    dp_t   dp;
  } uword_t;

  localparam addr_t A_IDLE  = 3'd0;
  localparam addr_t A_INIT  = 3'd1;
  localparam addr_t A_TEST  = 3'd2;
  localparam addr_t A_ADD   = 3'd3;
  localparam addr_t A_SHIFT = 3'd4;
  localparam addr_t A_LAST  = A_SHIFT;

  function automatic dp_t strobes(logic init, logic load, logic clrc, logic shdec);
    dp_t d;
    d = '0;
    d[DP_INIT]  = init;
    d[DP_LOAD]  = load;
    d[DP_CLRC]  = clrc;
    d[DP_SHDEC] = shdec;
    return d;
  endfunction

  function automatic uword_t mk_word(addr_t alt, addr_t dflt, seq_e s, dp_t d);
    uword_t w;
    w.nxt_alt  = alt;
    w.nxt_dflt = dflt;
    w.sel      = s;
    w.dp       = d;
    return w;
  endfunction

  // the microprogram; unused addresses hold a word that falls back to idle
  function automatic uword_t program_word(addr_t a);
    case (a)
      A_IDLE:  return mk_word(A_INIT, A_IDLE,  SQ_GO,   strobes(1'b0, 1'b0, 1'b0, 1'b0));
      A_INIT:  return mk_word(A_IDLE, A_TEST,  SQ_NEXT, strobes(1'b1, 1'b0, 1'b1, 1'b0));
      A_TEST:  return mk_word(A_ADD,  A_SHIFT, SQ_LSB,  strobes(1'b0, 1'b0, 1'b0, 1'b0));
      A_ADD:   return mk_word(A_IDLE, A_SHIFT, SQ_NEXT, strobes(1'b0, 1'b1, 1'b0, 1'b0));
      A_SHIFT: return mk_word(A_IDLE, A_TEST,  SQ_ZERO, strobes(1'b0, 1'b0, 1'b1, 1'b1));
      default: return mk_word(A_IDLE, A_IDLE,  SQ_NEXT, strobes(1'b0, 1'b0, 1'b0, 1'b0));
    endcase
  endfunction

  function automatic addr_t pick_next(uword_t w, logic take_alt);
    return take_alt ? w.nxt_alt : w.nxt_dflt;
  endfunction
endpackage

// File: rtl/mulseq_rom.sv
`timescale 1ns/1ps
module mulseq_rom
  import mulseq_pkg::*;
(
  input  addr_t  addr,
  output uword_t word
);
  uword_t store [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign store[i] = program_word(addr_t'(i));
  end

  assign word = store[addr];
endmodule

// File: rtl/mulseq_cond.sv
`timescale 1ns/1ps
module mulseq_cond
  import mulseq_pkg::*;
(
  input  seq_e sel,
  input  logic go,
  input  logic lsb,
  input  logic zero,
  output logic take_alt
);
  always_comb begin
    case (sel)
      SQ_NEXT: take_alt = 1'b0;
      SQ_GO:   take_alt = go;
      SQ_LSB:  take_alt = lsb;
      SQ_ZERO: take_alt = zero;
      default: take_alt = 1'b0;
    endcase
  end
endmodule

// File: rtl/mulseq_car.sv
`timescale 1ns/1ps
module mulseq_car
  import mulseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  uword_t word,
  input  logic   take_alt,
  output addr_t  addr
);
  addr_t next_addr;

  assign next_addr = pick_next(word, take_alt);

  always_ff @(posedge clk) begin
    if (rst) addr <= A_IDLE;
    else     addr <= next_addr;
  end
endmodule

// File: rtl/mul_seq_ctrl.sv
`timescale 1ns/1ps
module mul_seq_ctrl
  import mulseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic              mplr_lsb_i,
  input  logic              cnt_zero_i,
  output logic [ADDR_W-1:0] ctl_addr_o,
  output logic              init_o,
  output logic              load_o,
  output logic              clr_carry_o,
  output logic              shift_dec_o
);
  addr_t  cur_addr;
  uword_t cur_word;
  logic   take_alt;

  mulseq_rom u_rom (
    .addr (cur_addr),
    .word (cur_word)
  );

  mulseq_cond u_cond (
    .sel      (cur_word.sel),
    .go       (go_i),
    .lsb      (mplr_lsb_i),
    .zero     (cnt_zero_i),
    .take_alt (take_alt)
  );

  mulseq_car u_car (
    .clk      (clk),
    .rst      (rst),
    .word     (cur_word),
    .take_alt (take_alt),
    .addr     (cur_addr)
  );

  assign ctl_addr_o  = cur_addr;
  assign init_o      = cur_word.dp[DP_INIT];
  assign load_o      = cur_word.dp[DP_LOAD];
  assign clr_carry_o = cur_word.dp[DP_CLRC];
  assign shift_dec_o = cur_word.dp[DP_SHDEC];

  // reset marker for the reset check
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q) begin
      p_reset_idle_r1: assert (ctl_addr_o == A_IDLE && !init_o && !load_o && !shift_dec_o)
        else $error("reset did not land in idle");
    end
  end

  p_idle_go_r2: assert property (@(posedge clk) disable iff (rst)
    (ctl_addr_o == A_IDLE && go_i) |=> (ctl_addr_o == A_INIT));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (ctl_addr_o == A_IDLE && !go_i) |=> (ctl_addr_o == A_IDLE));

  p_init_fwd_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl_addr_o == A_INIT) |=> (ctl_addr_o == A_TEST));

  p_test_lsb_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_addr_o == A_TEST) |=> (ctl_addr_o == ($past(mplr_lsb_i) ? A_ADD : A_SHIFT)));

  p_add_fwd_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl_addr_o == A_ADD) |=> (ctl_addr_o == A_SHIFT));

  p_shift_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl_addr_o == A_SHIFT) |=> (ctl_addr_o == ($past(cnt_zero_i) ? A_IDLE : A_TEST)));

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
    $countones({init_o, load_o, shift_dec_o}) <= 1);

  p_legal_addr_r8: assert property (@(posedge clk) disable iff (rst)
    ##1 (ctl_addr_o <= A_LAST));
endmodule

// File: tb/mul_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mul_seq_ctrl_tb_top;
  localparam int N  = 4;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go  = 1'b0;
  logic use_model = 1'b0;
  logic f_lsb = 1'b0;
  logic f_zero = 1'b0;
  logic lsb, zero;
  logic [2:0] addr;
  logic s_init, s_load, s_clrc, s_shdec;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  // datapath model
  logic [N-1:0]  mA, mB, mQ;
  logic          mC;
  logic [PW-1:0] mP;
  logic [N-1:0]  op_b, op_q;

  assign lsb  = use_model ? mQ[0]        : f_lsb;
  assign zero = use_model ? (mP == '0)   : f_zero;

  always @(posedge clk) begin
    if (go && addr == 3'd0) begin
      mB <= op_b;
      mQ <= op_q;
    end
    if (s_init) begin
      mA <= '0;
      mP <= PW'(N-1);
    end
    if (s_clrc) mC <= 1'b0;
    if (s_load) {mC, mA} <= {1'b0, mA} + {1'b0, mB};
    if (s_shdec) begin
      mA <= {mC, mA[N-1:1]};
      mQ <= {mA[0], mQ[N-1:1]};
      mP <= mP - 1'b1;
    end
  end

  mul_seq_ctrl dut_i (
    .clk(clk), .rst(rst), .go_i(go), .mplr_lsb_i(lsb), .cnt_zero_i(zero),
    .ctl_addr_o(addr), .init_o(s_init), .load_o(s_load),
    .clr_carry_o(s_clrc), .shift_dec_o(s_shdec)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_next(int s, bit g, bit q, bit z);
    case (s)
      0: return g ? 1 : 0;
      1: return 2;
      2: return q ? 3 : 4;
      3: return 4;
      4: return z ? 0 : 2;
      default: return -1;
    endcase
  endfunction

  // {shift_dec, clr_carry, load, init}
  function automatic int exp_dp(int s);
    case (s)
      1: return 4'b0101;
      3: return 4'b0010;
      4: return 4'b1100;
      default: return 0;
    endcase
  endfunction

  function automatic int dp_now();
    return {s_shdec, s_clrc, s_load, s_init};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
    check("R1 address after reset", addr, 0);
    check("R1 strobes after reset", dp_now(), 0);
  endtask

  task automatic goto(int s);
    go = 0; f_lsb = 0; f_zero = 0;
    do_reset();
    if (s >= 1) begin go = 1; step(); go = 0; end
    if (s >= 2) step();
    if (s == 3) begin f_lsb = 1; step(); end
    if (s == 4) begin f_lsb = 0; step(); end
    f_lsb = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // walk each step under forced status lines, every combination
    for (int s = 0; s < 5; s++) begin
      for (int c = 0; c < 8; c++) begin
        goto(s);
        check("R8 reached address", addr, s);
        case (s)
          0: check("R2 idle strobes", dp_now(), exp_dp(s));
          1: check("R3 init strobes", dp_now(), exp_dp(s));
          2: check("R4 test strobes", dp_now(), exp_dp(s));
          3: check("R5 add strobes", dp_now(), exp_dp(s));
          default: check("R6 shift strobes", dp_now(), exp_dp(s));
        endcase
        go = c[0]; f_lsb = c[1]; f_zero = c[2];
        step();
        go = 0;
        // R7: unselected lines must not change the successor
        check("R7 successor under status combination", addr,
              exp_next(s, c[0], c[1], c[2]));
      end
    end

    // reset in the middle of a run
    goto(4);
    f_zero = 0;
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R1 reset from shift step", addr, 0);

    // exhaustive multiply sweep with the datapath model
    use_model = 1'b1;
    do_reset();
    for (int b = 0; b < (1 << N); b++) begin
      for (int q = 0; q < (1 << N); q++) begin
        int edges;
        int ones;
        op_b = N'(b);
        op_q = N'(q);
        go = 1;
        step();
        go = 0;
        check("R2 left idle on go", addr, 1);
        edges = 0;
        while (addr != 3'd0 && edges < 64) begin
          step();
          edges++;
          if (addr > 3'd4) check("R8 legal address", addr, 4);
        end
        ones = $countones(q[N-1:0]);
        check("R9 edges to idle", edges, 1 + 2*N + ones);
        check("R9 product", {mA, mQ}, b*q);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4ns * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule